// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block lets a system host accept notifications from bus devices that temporarily act as masters. It sits behind a byte-level I2C target engine, which reports start conditions, stop conditions and each received byte one clock at a time. The engine asks this block, during the byte's valid cycle, whether the byte is to be acknowledged.

A notification is a write to the host's fixed 7-bit address followed by three bytes. The first byte names the notifying device, with its 7-bit address in the upper bits. The second and third bytes carry a 16-bit status word, low byte first. Only a frame that ends with a stop right after the third byte is committed. On commit the block raises an interrupt and freezes the device address and status in holding registers until software acknowledges. A complete notification that arrives while one is still pending sets a sticky overrun flag and is otherwise dropped.

Top module: `smbus_notify_rx`

## Requirements
- R1: After reset `irq_o` and `overrun_o` are 0, and `dev_addr_o` and `status_o` are 0.
- R2: The first byte after a start is acknowledged, and opens a frame, only when it equals `{HOST_ADDR, 1'b0}`: the address is in bits 7:1 and bit 0 is 0 for a write. Any other first byte, including the read form, is not acknowledged, and the bytes that follow it up to the next start are neither acknowledged nor captured.
- R3: In an open frame the first three bytes after the address are acknowledged. A fourth or later byte is not.
- R4: The first byte after the address supplies `dev_addr_o` from its bits 7:1. Bit 0 is ignored.
- R5: The second byte after the address becomes `status_o[7:0]` and the third becomes `status_o[15:8]`.
- R6: A stop seen right after exactly three bytes commits the frame. `irq_o` is 1 in the cycle after the stop, with the captured values on `dev_addr_o` and `status_o`.
- R7: A frame that ends with a stop after fewer or more than three bytes is discarded. `irq_o` stays 0 and the held values are unchanged.
- R8: A start in the middle of a frame abandons it. The next byte is treated as an address byte again.
- R9: A complete frame that arrives while `irq_o` is 1 and `ack_i` is 0 sets `overrun_o`. The held values stay unchanged.
- R10: `ack_i` clears `irq_o` and `overrun_o` on the next cycle. If a frame completes in the same cycle, the new frame is loaded instead: `irq_o` stays 1 and `overrun_o` is 0.
- R11: While `irq_o` is 1 and no acknowledgement arrives, `dev_addr_o` and `status_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| stop_i | input | 1 | Stop seen on the bus (one-cycle pulse) |
| byte_vld_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge the current byte (valid while byte_vld_i is 1) |
| sw_ack_i | input | 1 | Software acknowledge of the pending notification |
| irq_o | output | 1 | Notification pending |
| overrun_o | output | 1 | A notification was dropped while one was pending |
| dev_addr_o | output | 7 | Held address of the notifying device |
| status_o | output | 16 | Held 16-bit status word |

## Verification
Frames are driven with a correct header and with several payloads. The payloads include odd first bytes, which show whether bit 0 leaks into the device address, and extreme status bytes, which show whether the low and high bytes are swapped. A read-form header and a foreign address check that the host address and the direction bit are both matched. Two-byte and four-byte frames check that the stop is counted exactly. Directed sequences cover a restart in mid-frame, a second frame arriving while one is pending, and an acknowledgement in the same cycle as a completion, which separates the overrun path from the reload path.

// File: rtl/smbus_notify_pkg.sv
package smbus_notify_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_BODY
  } rx_state_e;
endpackage

// File: rtl/smbus_notify_fsm.sv
module smbus_notify_fsm
  import smbus_notify_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          NUM_BYTES = 3,
  parameter int          CNT_W     = 3,
  parameter logic [BYTE_W-2:0] HOST_ADDR = 7'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_BYTES);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(NUM_BYTES + 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             addr_hit, byte_ev;

  assign addr_hit = (byte_i == {HOST_ADDR, 1'b0});
  assign byte_ev  = byte_vld_i && !start_i && !stop_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else if (byte_vld_i) begin
      unique case (state_q)
        ST_ADDR: state_d = addr_hit ? ST_BODY : ST_IDLE;
        ST_BODY: if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wr_en_o = byte_ev && (state_q == ST_BODY) && (cnt_q < CNT_FULL);
  assign ack_o   = (byte_ev && (state_q == ST_ADDR) && addr_hit) || wr_en_o;
  assign slot_o  = cnt_q;
  assign done_o  = stop_i && !start_i && (state_q == ST_BODY) && (cnt_q == CNT_FULL);

  // R3: byte counter saturates one past the payload
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);
  // R8: a start always reopens address phase
  a_r8_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR) && (cnt_q == '0));
  // R2: body only entered from a matching write address
  a_r2_body_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_BODY) && !start_i |=> (state_q == ST_BODY) -> $past(ack_o));
  // R7: a stop closes any frame
  a_r7_stop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/smbus_notify_capture.sv
module smbus_notify_capture #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 2,
  parameter int CNT_W      = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [CNT_W-1:0]             slot_i,
  input  logic [BYTE_W-1:0]            byte_i,
  output logic [BYTE_W-2:0]            dev_o,
  output logic [WORD_BYTES*BYTE_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       dev_o <= '0;
    else if (wr_en_i && slot_i == '0)  dev_o <= byte_i[BYTE_W-1:1];
  end

  // payload bytes land little-endian: slot k+1 -> byte lane k
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_o[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en_i && slot_i == CNT_W'(k + 1))
        word_o[k*BYTE_W +: BYTE_W] <= byte_i;
    end
  end

  // R4/R5: a write touches only the lane selected by its slot
  a_r5_lane_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && slot_i == '0 |=> $stable(word_o));
endmodule

// File: rtl/smbus_notify_hold.sv
module smbus_notify_hold #(
  parameter int DEV_W  = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              irq_o,
  output logic              ovr_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [WORD_W-1:0] word_o
);
  logic load;
  assign load = done_i && (!irq_o || ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      ovr_o  <= 1'b0;
      dev_o  <= '0;
      word_o <= '0;
    end else if (load) begin
      irq_o  <= 1'b1;
      ovr_o  <= 1'b0;
      dev_o  <= dev_i;
      word_o <= word_i;
    end else if (done_i) begin
      ovr_o  <= 1'b1;
    end else if (ack_i) begin
      irq_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end
  end

  a_r6_irq_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i));
  a_r9_ovr_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(irq_o) && !$past(ack_i));
  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> $stable(dev_o) && $stable(word_o));
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !done_i |=> !irq_o && !ovr_o);
  a_r10_ack_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && done_i |=> irq_o && !ovr_o);
endmodule

// File: rtl/smbus_notify_rx.sv
module smbus_notify_rx #(
  parameter int          BYTE_W     = 8,
  parameter int          WORD_BYTES = 2,
  parameter logic [BYTE_W-2:0] HOST_ADDR = 7'h08
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic                         byte_vld_i,
  input  logic [BYTE_W-1:0]            byte_i,
  output logic                         ack_o,
  input  logic                         sw_ack_i,
  output logic                         irq_o,
  output logic                         overrun_o,
  output logic [BYTE_W-2:0]            dev_addr_o,
  output logic [WORD_BYTES*BYTE_W-1:0] status_o
);
  localparam int DEV_W     = BYTE_W - 1;
  localparam int WORD_W    = WORD_BYTES * BYTE_W;
  localparam int NUM_BYTES = WORD_BYTES + 1;
  localparam int CNT_W     = $clog2(NUM_BYTES + 2);

  logic             wr_en, done;
  logic [CNT_W-1:0] slot;
  logic [DEV_W-1:0] stage_dev;
  logic [WORD_W-1:0] stage_word;

  smbus_notify_fsm #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W), .HOST_ADDR(HOST_ADDR)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_i,
    .ack_o, .wr_en_o(wr_en), .slot_o(slot), .done_o(done)
  );

  smbus_notify_capture #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
  ) u_capture (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .slot_i(slot), .byte_i,
    .dev_o(stage_dev), .word_o(stage_word)
  );

  smbus_notify_hold #(
    .DEV_W(DEV_W), .WORD_W(WORD_W)
  ) u_hold (
    .clk_i, .rst_ni, .done_i(done), .ack_i(sw_ack_i),
    .dev_i(stage_dev), .word_i(stage_word),
    .irq_o, .ovr_o(overrun_o), .dev_o(dev_addr_o), .word_o(status_o)
  );

  // R3: acknowledge only ever answers a byte
  a_r3_ack_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> byte_vld_i);
endmodule

// File: tb/smbus_notify_rx_bench.sv
module smbus_notify_rx_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, sw_ack_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        ack_o, irq_o, overrun_o;
  logic [6:0]  dev_addr_o;
  logic [15:0] status_o;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  smbus_notify_rx u_smbus_notify_rx (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_i, .ack_o,
    .sw_ack_i, .irq_o, .overrun_o, .dev_addr_o, .status_o
  );

  typedef struct packed {
    logic [7:0]  adr;
    logic [2:0]  n;
    logic [31:0] bytes;
    logic        exp_irq;
    logic [6:0]  exp_dev;
    logic [15:0] exp_stat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 3'd3, 32'h0012_345A, 1'b1, 7'h2D, 16'h1234},  // R4 R5 R6
    '{8'h10, 3'd3, 32'h00AB_CD5B, 1'b1, 7'h2D, 16'hABCD},  // R4 bit0 ignored
    '{8'h11, 3'd3, 32'h0077_6655, 1'b0, 7'h2D, 16'hABCD},  // R2 read form
    '{8'h12, 3'd3, 32'h0077_6655, 1'b0, 7'h2D, 16'hABCD},  // R2 foreign address
    '{8'h10, 3'd2, 32'h0000_6655, 1'b0, 7'h2D, 16'hABCD},  // R7 short
    '{8'h10, 3'd4, 32'h0403_0201, 1'b0, 7'h2D, 16'hABCD},  // R7 long
    '{8'h10, 3'd3, 32'h00FF_00FE, 1'b1, 7'h7F, 16'hFF00}   // R5 extremes
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    #1;
  endtask

  task automatic do_byte(input logic [7:0] b, input logic exp_ack, input string req);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    #1 chk(req, 32'(ack_o), 32'(exp_ack));
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic do_sw_ack();
    @(negedge clk); sw_ack_i = 1'b1;
    @(negedge clk); sw_ack_i = 1'b0;
    #1;
    chk("R10 irq cleared", 32'(irq_o), 32'd0);
    chk("R10 overrun cleared", 32'(overrun_o), 32'd0);
  endtask

  task automatic frame(input logic [7:0] d0, input logic [7:0] lo, input logic [7:0] hi);
    do_start();
    do_byte(8'h10, 1'b1, "R2 address ack");
    do_byte(d0, 1'b1, "R3 ack");
    do_byte(lo, 1'b1, "R3 ack");
    do_byte(hi, 1'b1, "R3 ack");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 overrun", 32'(overrun_o), 32'd0);
    chk("R1 dev", 32'(dev_addr_o), 32'd0);
    chk("R1 status", 32'(status_o), 32'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic hit;
      hit = (VECS[v].adr == 8'h10);
      do_start();
      do_byte(VECS[v].adr, hit, "R2 address ack");
      for (int i = 0; i < int'(VECS[v].n); i++)
        do_byte(VECS[v].bytes[8*i +: 8], hit && (i < 3), "R3 body ack");
      do_stop();
      chk("R6/R7 irq", 32'(irq_o), 32'(VECS[v].exp_irq));
      chk("R4 dev", 32'(dev_addr_o), 32'(VECS[v].exp_dev));
      chk("R5 status", 32'(status_o), 32'(VECS[v].exp_stat));
      if (VECS[v].exp_irq) do_sw_ack();
    end

    // R8: restart mid-frame, then full frame
    do_start();
    do_byte(8'h10, 1'b1, "R8 address ack");
    do_byte(8'h22, 1'b1, "R8 first body ack");
    do_start();
    do_byte(8'h66, 1'b0, "R8 byte after restart is address");
    do_start();
    do_byte(8'h10, 1'b1, "R8 address ack");
    do_byte(8'h22, 1'b1, "R8 ack");
    do_stop();
    chk("R8 abandoned frame no irq", 32'(irq_o), 32'd0);
    frame(8'h44, 8'h11, 8'h99);
    do_stop();
    chk("R8 irq", 32'(irq_o), 32'd1);
    chk("R8 dev", 32'(dev_addr_o), 32'h22);
    chk("R8 status", 32'(status_o), 32'h9911);

    // R9: second frame while pending
    frame(8'h08, 8'h01, 8'h02);
    do_stop();
    chk("R9 overrun", 32'(overrun_o), 32'd1);
    chk("R9 irq", 32'(irq_o), 32'd1);
    chk("R11 dev held", 32'(dev_addr_o), 32'h22);
    chk("R11 status held", 32'(status_o), 32'h9911);
    do_sw_ack();
    chk("R11 dev after ack", 32'(dev_addr_o), 32'h22);

    // R10: ack in the same cycle as completion
    frame(8'h0A, 8'h33, 8'h44);
    do_stop();
    frame(8'h0C, 8'h55, 8'h66);
    frame(8'h0E, 8'h77, 8'h88);
    chk("R9 overrun before reload", 32'(overrun_o), 32'd0);
    @(negedge clk); stop_i = 1'b1; sw_ack_i = 1'b1;
    @(negedge clk); stop_i = 1'b0; sw_ack_i = 1'b0;
    #1;
    chk("R10 reload irq", 32'(irq_o), 32'd1);
    chk("R10 reload overrun", 32'(overrun_o), 32'd0);
    chk("R10 reload dev", 32'(dev_addr_o), 32'h07);
    chk("R10 reload status", 32'(status_o), 32'h8877);
    do_sw_ack();

    // R7: stop without frame, and ack while idle
    do_stop();
    chk("R7 lone stop", 32'(irq_o), 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule